// File: doc/BRIEF.md
# Latched Wired-OR Bus Transceiver

This block joins a set of independent channels (three by default) between a local three-state A port and an open-collector B line on a shared wired-OR bus. Each channel has a storage latch. While the channel's active-low capture control is low, the latch is transparent to the A input. When the control rises, the latch keeps the A value from the last clock edge at which the control was low. Through an active-low B enable, the latch value decides whether the channel pulls its B line low or releases it. An active-high A enable drives the A port from the level sensed on the B line.

The chip-level pad ring resolves the bus, so the block has no internal tri-states. The A side is split into an input, an output value and an output enable. The B side is split into a pull-low request, a sensed level and a flag that says whether the sensed level is actually driven. If the latch is transparent while both enables are active, a loop forms from A through B and back to A. A per-channel hazard output flags this case. Every channel may run in any mode, whatever the other channels are doing. The pins are plain level controls, so there is no valid/ready flow and no back-pressure.

Top module: `wor_latch_xcvr`

## Requirements
- R1: Each channel's outputs depend only on that channel's own inputs and latch, so the channels can run in different modes in the same cycle.
- R2: While `le_n[i]` is 0, the latch is transparent: the latch value equals `a_in[i]` in the same cycle.
- R3: While `le_n[i]` is 1, the latch holds the `a_in[i]` value sampled at the last rising clock edge at which `le_n[i]` was 0. Changes on `a_in[i]` then have no effect on `b_pull[i]`.
- R4: When `oeb_n[i]` is 0, `b_pull[i]` is 1 exactly when the latch value is 0. A latch value of 1 releases the line.
- R5: When `oeb_n[i]` is 1, `b_pull[i]` is 0 whatever the latch holds.
- R6: `a_oe[i]` equals `oea[i]`. When `oea[i]` is 1, `a_out[i]` equals the sensed B level. When `oea[i]` is 0, `a_out[i]` is 0.
- R7: `hazard[i]` is 1 exactly when `le_n[i]`=0, `oeb_n[i]`=0 and `oea[i]`=1.
- R8: In preconditioned mode (`le_n`=1, `oeb_n`=0, `oea`=1), B is driven from the held value and `a_out` reflects the resulting B level.
- R9: When `b_sense_ok[i]` is 0, the B line counts as floating and is read as 0 on `a_out[i]`.
- R10: The asynchronous active-low reset sets every latch to 1. With `le_n` high and `oeb_n` low, no B line is pulled low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the latch is captured on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| le_n | input | NCH | Per-channel latch transparency control, active low |
| oea | input | NCH | Per-channel A drive enable, active high |
| oeb_n | input | NCH | Per-channel B drive enable, active low |
| a_in | input | NCH | Level present on each A pin |
| a_out | output | NCH | Value driven onto each A pin |
| a_oe | output | NCH | A pin drive enable |
| b_pull | output | NCH | Request to pull each B line low |
| b_sense | input | NCH | Sensed level of each B line |
| b_sense_ok | input | NCH | 1 when the B line is driven or pulled up; 0 when floating |
| hazard | output | NCH | Feedback-loop hazard flag per channel |

## Verification
`b_pull`, `a_oe`, `a_out` and `hazard` are combinational from the inputs and the held latch, so each is due in the same cycle its inputs change. A new captured value affects the outputs only from the cycle after the rising edge at which `le_n` was low. The bench drives inputs on the falling edge and checks outputs 2 ns later. It updates its own held-value model only after the following rising edge. A closed check therefore never mixes the old and new latch contents.

// File: rtl/wor_xcvr_pkg.sv
package wor_xcvr_pkg;

  // Decoded per-channel control, all active high.
  typedef struct packed {
    logic open;  // latch transparent
    logic b_en;  // B pull-low path enabled
    logic a_en;  // A drive enabled
  } chan_ctl_t;

  function automatic chan_ctl_t decode_ctl(input logic le_n, input logic oea,
                                           input logic oeb_n);
    chan_ctl_t c;
    c.open = ~le_n;
    c.b_en = ~oeb_n;
    c.a_en = oea;
    return c;
  endfunction

endpackage

// File: rtl/wor_latch_cell.sv
module wor_latch_cell
  import wor_xcvr_pkg::*;
#(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  chan_ctl_t ctl,
  input  logic      d,
  output logic      q
);
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= RESET_VAL;
    else if (ctl.open) held <= d;
  end

  // transparent path is combinational so the value flows in the same cycle
  assign q = ctl.open ? d : held;
endmodule

// File: rtl/wor_bport.sv
module wor_bport
  import wor_xcvr_pkg::*;
(
  input  chan_ctl_t ctl,
  input  logic      latch_q,
  output logic      pull
);
  // open-collector: only ever pull low, never drive high
  assign pull = ctl.b_en & ~latch_q;
endmodule

// File: rtl/wor_aport.sv
module wor_aport
  import wor_xcvr_pkg::*;
(
  input  chan_ctl_t ctl,
  input  logic      sense,
  input  logic      sense_ok,
  output logic      drv,
  output logic      oe
);
  logic level;
  // an undriven line reads as low
  assign level = sense & sense_ok;
  assign oe    = ctl.a_en;
  assign drv   = ctl.a_en & level;
endmodule

// File: rtl/wor_latch_xcvr.sv
module wor_latch_xcvr
  import wor_xcvr_pkg::*;
#(
  parameter int   NCH         = 3,
  parameter logic LATCH_RESET = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] le_n,
  input  logic [NCH-1:0] oea,
  input  logic [NCH-1:0] oeb_n,
  input  logic [NCH-1:0] a_in,
  output logic [NCH-1:0] a_out,
  output logic [NCH-1:0] a_oe,
  output logic [NCH-1:0] b_pull,
  input  logic [NCH-1:0] b_sense,
  input  logic [NCH-1:0] b_sense_ok,
  output logic [NCH-1:0] hazard
);
  localparam int LAST = NCH - 1;

  for (genvar i = 0; i <= LAST; i++) begin : g_ch
    chan_ctl_t ctl;
    logic      q;

    assign ctl = decode_ctl(le_n[i], oea[i], oeb_n[i]);

    wor_latch_cell #(.RESET_VAL(LATCH_RESET)) u_latch (
      .clk  (clk),
      .rst_n(rst_n),
      .ctl  (ctl),
      .d    (a_in[i]),
      .q    (q)
    );

    wor_bport u_b (
      .ctl    (ctl),
      .latch_q(q),
      .pull   (b_pull[i])
    );

    wor_aport u_a (
      .ctl     (ctl),
      .sense   (b_sense[i]),
      .sense_ok(b_sense_ok[i]),
      .drv     (a_out[i]),
      .oe      (a_oe[i])
    );

    // loop A -> latch -> B -> A is closed only with all three paths open
    assign hazard[i] = ctl.open & ctl.b_en & ctl.a_en;
  end
endmodule

// File: rtl/wor_latch_xcvr_chk.sv
module wor_latch_xcvr_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] le_n,
  input logic [NCH-1:0] oea,
  input logic [NCH-1:0] oeb_n,
  input logic [NCH-1:0] a_out,
  input logic [NCH-1:0] a_oe,
  input logic [NCH-1:0] b_pull,
  input logic [NCH-1:0] b_sense_ok,
  input logic [NCH-1:0] hazard
);
  // R5
  a_r5_released_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (oeb_n & b_pull) == '0);

  // R6
  a_r6_quiet_when_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (~a_oe & a_out) == '0);

  // R9
  a_r9_float_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
    (~b_sense_ok & a_out) == '0);

  // R7
  a_r7_hazard_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (hazard & (oeb_n | ~a_oe)) == '0);

  // R3
  a_r3_hold_keeps_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (le_n & $past(le_n) & ~oeb_n & ~$past(oeb_n) & (b_pull ^ $past(b_pull))) == '0);

  // R10
  a_r10_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ((b_pull & le_n) == '0));
endmodule

bind wor_latch_xcvr wor_latch_xcvr_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .le_n      (le_n),
  .oea       (oea),
  .oeb_n     (oeb_n),
  .a_out     (a_out),
  .a_oe      (a_oe),
  .b_pull    (b_pull),
  .b_sense_ok(b_sense_ok),
  .hazard    (hazard)
);

// File: tb/wor_latch_xcvr_test.sv
module wor_latch_xcvr_test;
  localparam int NCH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] le_n = '1, oea = '0, oeb_n = '1, a_in = '0;
  logic [NCH-1:0] ext_low = '0, b_sense_ok = '1;
  logic [NCH-1:0] a_out, a_oe, b_pull, hazard, b_sense;
  logic [NCH-1:0] ref_q = '1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  // wired bus: low if the block or an external driver pulls it
  assign b_sense = ~(b_pull | ext_low);

  wor_latch_xcvr #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .le_n(le_n), .oea(oea), .oeb_n(oeb_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_pull(b_pull),
    .b_sense(b_sense), .b_sense_ok(b_sense_ok), .hazard(hazard)
  );

  function automatic logic exp_q(int i);
    return le_n[i] ? ref_q[i] : a_in[i];
  endfunction
  function automatic logic exp_pull(int i);
    return ~oeb_n[i] & ~exp_q(i);
  endfunction
  function automatic logic exp_aout(int i);
    return oea[i] & b_sense_ok[i] & ~(exp_pull(i) | ext_low[i]);
  endfunction
  function automatic logic exp_haz(int i);
    return ~le_n[i] & ~oeb_n[i] & oea[i];
  endfunction

  task automatic check1(string req, string ctx, int ch, string sig, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) ch%0d %s actual=%b expected=%b", req, ctx, ch, sig, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    for (int i = 0; i < NCH; i++) begin
      check1(oeb_n[i] ? "R5" : "R4", ctx, i, "b_pull", b_pull[i], exp_pull(i));
      check1("R6", ctx, i, "a_oe", a_oe[i], oea[i]);
      check1(b_sense_ok[i] ? "R6" : "R9", ctx, i, "a_out", a_out[i], exp_aout(i));
      check1("R7", ctx, i, "hazard", hazard[i], exp_haz(i));
    end
  endtask

  task automatic step(input logic [NCH-1:0] le, oa, ob, ain, ext, ok, input string ctx);
    @(negedge clk);
    le_n = le; oea = oa; oeb_n = ob; a_in = ain; ext_low = ext; b_sense_ok = ok;
    #2;
    check_all(ctx);
    @(posedge clk);
    for (int i = 0; i < NCH; i++) if (!le_n[i]) ref_q[i] = a_in[i];
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    // R10: during reset, hold mode, B enabled -> latches at 1, nothing pulled
    @(negedge clk);
    le_n = '1; oeb_n = '0; oea = '0; a_in = '0;
    #2;
    for (int i = 0; i < NCH; i++) check1("R10", "in reset", i, "b_pull", b_pull[i], 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step('1, '0, '0, '0, '0, '1, "R10 after reset");
    // R2: transparent, B follows A in the same cycle
    step('0, '0, '0, 3'b010, '0, '1, "R2 transparent");
    step('0, '0, '0, 3'b101, '0, '1, "R2 transparent flip");
    // R3: close the latch, then wiggle A; held value 101 must stay
    step('1, '0, '0, 3'b010, '0, '1, "R3 hold");
    step('1, '0, '0, 3'b111, '0, '1, "R3 hold A changed");
    step('1, '0, '1, 3'b000, '0, '1, "R5 B disabled");
    // R8: preconditioned on all channels, A reflects B
    step('1, '1, '0, 3'b000, '0, '1, "R8 precond");
    step('1, '1, '0, 3'b000, 3'b001, '1, "R8 precond ext low");
    // R1: mixed modes at once: ch0 A->B, ch1 preconditioned, ch2 feedback
    step(3'b010, 3'b110, 3'b000, 3'b100, '0, '1, "R1 mixed modes");
    // ch0 B->A, ch1 isolated, ch2 hold to A+B
    step(3'b110, 3'b101, 3'b011, 3'b000, 3'b001, '1, "R1 mixed modes 2");
    // R9: floating lines read low
    step('1, '1, '1, '0, '0, 3'b010, "R9 floating");
    // R7: all feedback
    step('0, '1, '0, 3'b011, '0, '1, "R7 feedback");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [NCH-1:0] r_le, r_oa, r_ob, r_a, r_ext, r_ok;
      r_le = NCH'($urandom); r_oa = NCH'($urandom); r_ob = NCH'($urandom);
      r_a = NCH'($urandom); r_ext = NCH'($urandom) & NCH'($urandom);
      r_ok = NCH'($urandom) | NCH'($urandom) | NCH'($urandom);
      step(r_le, r_oa, r_ob, r_a, r_ext, r_ok, "R1 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule